// File: doc/BRIEF.md
# Home-Node Line Directory Controller

This block sits at the home node of a cache-coherent machine with non-uniform memory access. Every memory line homed at this node has one entry in a local table. The entry records whether some node holds the line and, if so, which one. A remote node that wants a line sends a request carrying a physical address and its own node number. The controller then does one of two things. It either fetches the line from local memory and returns it to the requester, or it tells the node that currently holds the line to pass it on and drop its own copy. In both cases it then records the requester as the holder.

Each entry tracks a single holder, so handing a line over always costs one forward-and-invalidate message and never a broadcast. The controller works on one request at a time and signals this on `busy_o`. Every accepted request produces exactly one outgoing message. The memory read port has a variable latency, and the reply waits for its data strobe.

Top module: `home_dir_ctrl`

## Requirements
- R1: The request address is split, from the least significant bit up, into an OFS_W-bit byte offset, a LINE_W-bit line index and an NODE_W-bit home-node field. Only the line index selects the table entry, and the offset and home-node fields never change the outcome. The line index is what appears on `mem_line_o` and `msg_line_o`.
- R2: After reset every entry is uncached. `busy_o`, `mem_rd_o` and `msg_valid_o` are low until a request is accepted.
- R3: For a request to an uncached line, `mem_rd_o` is high for exactly one cycle, in the cycle after the accepting edge, with that line on `mem_line_o`. In the cycle after the edge that samples `mem_rvalid_i` high, `msg_valid_o` is high with these fields: `msg_type_o` = 0 (data reply), `msg_dst_o` = `msg_req_o` = requester, and `msg_data_o` equal to the sampled `mem_rdata_i`.
- R4: Once a request to an uncached line has been served, the entry records the line as cached at the requesting node.
- R5: For a request to a line cached at a different node, no memory read is made. `msg_valid_o` is high in the second cycle after the accepting edge, with these fields: `msg_type_o` = 1 (forward and invalidate), `msg_dst_o` = previous holder, `msg_req_o` = requester, and `msg_data_o` = 0. The entry then names the requester.
- R6: A request from the node that already holds the line is answered with a data reply from memory, exactly as in R3, and the entry is left unchanged.
- R7: A request is accepted only at a rising edge where `req_valid_i` is high and `busy_o` is low. `busy_o` is high from the cycle after acceptance up to the cycle in which the message is issued, and it is low in that cycle. A request presented while `busy_o` is high is ignored.
- R8: Each accepted request yields exactly one message, and `msg_valid_o` stays high for a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | NODE_W+LINE_W+OFS_W | Physical address of the requested line |
| req_src_i | input | NODE_W | Requesting node |
| busy_o | output | 1 | A request is in progress |
| mem_rd_o | output | 1 | Local memory read strobe |
| mem_line_o | output | LINE_W | Line to read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| msg_valid_o | output | 1 | Outgoing message valid |
| msg_type_o | output | 1 | 0 data reply, 1 forward and invalidate |
| msg_dst_o | output | NODE_W | Destination node |
| msg_req_o | output | NODE_W | Node that asked for the line |
| msg_line_o | output | LINE_W | Line index |
| msg_data_o | output | DATA_W | Line data on a reply, zero on a forward |

## Verification
The bench builds the controller with NODE_W=3, LINE_W=4, OFS_W=2 and DATA_W=16. With 16 lines and 8 nodes, every pair of line and requester can be swept in full, so each entry passes through the uncached, self-held and foreign-held cases. A pseudo-random pass then scrambles the offset and home-node fields on every request. A fixed two-cycle memory latency makes the reply and forward latencies exact numbers that the bench can check. A request injected while the controller is busy is followed by a probe of the line that request named.

// File: rtl/coh_dir_pkg.sv
package coh_dir_pkg;

  typedef enum logic {
    MSG_DATA_REPLY = 1'b0,
    MSG_FWD_INV    = 1'b1
  } msg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_MEM  = 2'd2
  } ctl_state_e;

endpackage

// File: rtl/coh_addr_split.sv
module coh_addr_split #(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFS_W  = 6,
  localparam int unsigned ADDR_W = NODE_W + LINE_W + OFS_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [NODE_W-1:0] node_o,
  output logic [LINE_W-1:0] line_o,
  output logic [OFS_W-1:0]  ofs_o
);

  assign ofs_o  = addr_i[OFS_W-1:0];
  assign line_o = addr_i[OFS_W +: LINE_W];
  assign node_o = addr_i[ADDR_W-1 -: NODE_W];

endmodule

// File: rtl/coh_dir_table.sv
module coh_dir_table #(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned LINE_W = 10,
  localparam int unsigned DEPTH = 1 << LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [LINE_W-1:0] rd_idx_i,
  output logic              rd_cached_o,
  output logic [NODE_W-1:0] rd_holder_o,
  input  logic              wr_en_i,
  input  logic [LINE_W-1:0] wr_idx_i,
  input  logic [NODE_W-1:0] wr_holder_i
);

  logic [DEPTH-1:0]  cached_q;
  logic [NODE_W-1:0] holder_q [DEPTH];
  logic              rd_cached_q;
  logic [NODE_W-1:0] rd_holder_q;

  // per-entry cached flag: cleared by reset, set on first ownership
  for (genvar i = 0; i < DEPTH; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cached_q[i] <= 1'b0;
      end else if (wr_en_i && (wr_idx_i == LINE_W'(i))) begin
        cached_q[i] <= 1'b1;
      end
    end
  end

  // holder field only meaningful while flag set: no reset needed
  always_ff @(posedge clk_i) begin
    if (wr_en_i) holder_q[wr_idx_i] <= wr_holder_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cached_q <= 1'b0;
      rd_holder_q <= '0;
    end else if (rd_en_i) begin
      rd_cached_q <= cached_q[rd_idx_i];
      rd_holder_q <= holder_q[rd_idx_i];
    end
  end

  assign rd_cached_o = rd_cached_q;
  assign rd_holder_o = rd_holder_q;

endmodule

// File: rtl/coh_dir_fsm.sv
module coh_dir_fsm
  import coh_dir_pkg::*;
#(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [LINE_W-1:0] req_line_i,
  input  logic [NODE_W-1:0] req_src_i,
  output logic              busy_o,
  output logic              tbl_rd_en_o,
  output logic [LINE_W-1:0] tbl_rd_idx_o,
  input  logic              tbl_cached_i,
  input  logic [NODE_W-1:0] tbl_holder_i,
  output logic              tbl_wr_en_o,
  output logic [LINE_W-1:0] tbl_wr_idx_o,
  output logic [NODE_W-1:0] tbl_wr_holder_o,
  output logic              mem_rd_o,
  output logic [LINE_W-1:0] mem_line_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              out_load_o,
  output msg_kind_e         out_kind_o,
  output logic [NODE_W-1:0] out_dst_o,
  output logic [NODE_W-1:0] out_req_o,
  output logic [LINE_W-1:0] out_line_o,
  output logic [DATA_W-1:0] out_data_o
);

  ctl_state_e        state_q;
  logic [NODE_W-1:0] src_q;
  logic [LINE_W-1:0] line_q;
  logic              keep_q;   // requester already holds the line
  logic              accept;
  logic              fwd;

  assign accept = req_valid_i && (state_q == ST_IDLE);
  assign fwd    = tbl_cached_i && (tbl_holder_i != src_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      src_q   <= '0;
      line_q  <= '0;
      keep_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_LOOK;
            src_q   <= req_src_i;
            line_q  <= req_line_i;
          end
        end
        ST_LOOK: begin
          keep_q  <= tbl_cached_i;
          state_q <= fwd ? ST_IDLE : ST_MEM;
        end
        ST_MEM: begin
          if (mem_rvalid_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy_o          = (state_q != ST_IDLE);
    tbl_rd_en_o     = accept;
    tbl_rd_idx_o    = req_line_i;
    tbl_wr_en_o     = 1'b0;
    tbl_wr_idx_o    = line_q;
    tbl_wr_holder_o = src_q;
    mem_rd_o        = 1'b0;
    mem_line_o      = line_q;
    out_load_o      = 1'b0;
    out_kind_o      = MSG_DATA_REPLY;
    out_dst_o       = src_q;
    out_req_o       = src_q;
    out_line_o      = line_q;
    out_data_o      = '0;
    unique case (state_q)
      ST_LOOK: begin
        if (fwd) begin
          tbl_wr_en_o = 1'b1;
          out_load_o  = 1'b1;
          out_kind_o  = MSG_FWD_INV;
          out_dst_o   = tbl_holder_i;
        end else begin
          mem_rd_o = 1'b1;
        end
      end
      ST_MEM: begin
        if (mem_rvalid_i) begin
          tbl_wr_en_o = !keep_q;
          out_load_o  = 1'b1;
          out_data_o  = mem_rdata_i;
        end
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/coh_msg_reg.sv
module coh_msg_reg
  import coh_dir_pkg::*;
#(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  msg_kind_e         kind_i,
  input  logic [NODE_W-1:0] dst_i,
  input  logic [NODE_W-1:0] req_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output msg_kind_e         kind_o,
  output logic [NODE_W-1:0] dst_o,
  output logic [NODE_W-1:0] req_o,
  output logic [LINE_W-1:0] line_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      kind_o  <= MSG_DATA_REPLY;
      dst_o   <= '0;
      req_o   <= '0;
      line_o  <= '0;
      data_o  <= '0;
    end else begin
      valid_o <= load_i;
      if (load_i) begin
        kind_o <= kind_i;
        dst_o  <= dst_i;
        req_o  <= req_i;
        line_o <= line_i;
        data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/home_dir_ctrl.sv
module home_dir_ctrl
  import coh_dir_pkg::*;
#(
  parameter int unsigned NODE_W = 8,
  parameter int unsigned LINE_W = 10,
  parameter int unsigned OFS_W  = 6,
  parameter int unsigned DATA_W = 64,
  localparam int unsigned ADDR_W = NODE_W + LINE_W + OFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [NODE_W-1:0] req_src_i,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic [LINE_W-1:0] mem_line_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              msg_valid_o,
  output logic              msg_type_o,
  output logic [NODE_W-1:0] msg_dst_o,
  output logic [NODE_W-1:0] msg_req_o,
  output logic [LINE_W-1:0] msg_line_o,
  output logic [DATA_W-1:0] msg_data_o
);

  logic [NODE_W-1:0] a_node;
  logic [LINE_W-1:0] a_line;
  logic [OFS_W-1:0]  a_ofs;
  logic              unused_fields;

  logic              t_rd_en, t_cached, t_wr_en;
  logic [LINE_W-1:0] t_rd_idx, t_wr_idx;
  logic [NODE_W-1:0] t_holder, t_wr_holder;

  logic              o_load;
  msg_kind_e         o_kind, m_kind;
  logic [NODE_W-1:0] o_dst, o_req;
  logic [LINE_W-1:0] o_line;
  logic [DATA_W-1:0] o_data;

  coh_addr_split #(.NODE_W(NODE_W), .LINE_W(LINE_W), .OFS_W(OFS_W)) u_split (
    .addr_i (req_addr_i),
    .node_o (a_node),
    .line_o (a_line),
    .ofs_o  (a_ofs)
  );

  // routing already delivered the request here; offset is below line granularity
  assign unused_fields = ^{a_node, a_ofs};

  coh_dir_table #(.NODE_W(NODE_W), .LINE_W(LINE_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (t_rd_en),
    .rd_idx_i    (t_rd_idx),
    .rd_cached_o (t_cached),
    .rd_holder_o (t_holder),
    .wr_en_i     (t_wr_en),
    .wr_idx_i    (t_wr_idx),
    .wr_holder_i (t_wr_holder)
  );

  coh_dir_fsm #(.NODE_W(NODE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_line_i      (a_line),
    .req_src_i       (req_src_i),
    .busy_o          (busy_o),
    .tbl_rd_en_o     (t_rd_en),
    .tbl_rd_idx_o    (t_rd_idx),
    .tbl_cached_i    (t_cached),
    .tbl_holder_i    (t_holder),
    .tbl_wr_en_o     (t_wr_en),
    .tbl_wr_idx_o    (t_wr_idx),
    .tbl_wr_holder_o (t_wr_holder),
    .mem_rd_o        (mem_rd_o),
    .mem_line_o      (mem_line_o),
    .mem_rvalid_i    (mem_rvalid_i),
    .mem_rdata_i     (mem_rdata_i),
    .out_load_o      (o_load),
    .out_kind_o      (o_kind),
    .out_dst_o       (o_dst),
    .out_req_o       (o_req),
    .out_line_o      (o_line),
    .out_data_o      (o_data)
  );

  coh_msg_reg #(.NODE_W(NODE_W), .LINE_W(LINE_W), .DATA_W(DATA_W)) u_msg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (o_load),
    .kind_i  (o_kind),
    .dst_i   (o_dst),
    .req_i   (o_req),
    .line_i  (o_line),
    .data_i  (o_data),
    .valid_o (msg_valid_o),
    .kind_o  (m_kind),
    .dst_o   (msg_dst_o),
    .req_o   (msg_req_o),
    .line_o  (msg_line_o),
    .data_o  (msg_data_o)
  );

  assign msg_type_o = m_kind;

endmodule

// File: rtl/coh_dir_checker.sv
module coh_dir_checker #(
  parameter int unsigned NODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              busy_o,
  input logic              mem_rd_o,
  input logic              mem_rvalid_i,
  input logic              msg_valid_o,
  input logic              msg_type_o,
  input logic [NODE_W-1:0] msg_dst_o,
  input logic [NODE_W-1:0] msg_req_o
);

  a_r7_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> busy_o);

  a_r7_idle_on_msg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> !busy_o);

  a_r7_mem_only_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);

  a_r8_msg_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> !msg_valid_o);

  a_r3_mem_rd_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);

  a_r3_reply_follows_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_type_o) |-> $past(mem_rvalid_i));

  a_r3_reply_to_requester: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_type_o) |-> (msg_dst_o == msg_req_o));

  a_r5_fwd_to_other: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && msg_type_o) |-> (msg_dst_o != msg_req_o));

endmodule

bind home_dir_ctrl coh_dir_checker #(.NODE_W(NODE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .busy_o       (busy_o),
  .mem_rd_o     (mem_rd_o),
  .mem_rvalid_i (mem_rvalid_i),
  .msg_valid_o  (msg_valid_o),
  .msg_type_o   (msg_type_o),
  .msg_dst_o    (msg_dst_o),
  .msg_req_o    (msg_req_o)
);

// File: tb/sim_home_dir_ctrl.sv
`timescale 1ns/1ps
module sim_home_dir_ctrl;

  localparam int unsigned NW = 3;
  localparam int unsigned LW = 4;
  localparam int unsigned OW = 2;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = NW + LW + OW;
  localparam int NLINES  = 1 << LW;
  localparam int NNODES  = 1 << NW;
  localparam int MEM_LAT = 2;
  localparam logic [LW-1:0] INTR_LINE = LW'(5);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_valid_i = 1'b0;
  logic [AW-1:0] req_addr_i = '0;
  logic [NW-1:0] req_src_i = '0;
  logic          busy_o, mem_rd_o, mem_rvalid_i = 1'b0;
  logic [LW-1:0] mem_line_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic          msg_valid_o, msg_type_o;
  logic [NW-1:0] msg_dst_o, msg_req_o;
  logic [LW-1:0] msg_line_o;
  logic [DW-1:0] msg_data_o;

  always #4 clk_i = ~clk_i;

  home_dir_ctrl #(.NODE_W(NW), .LINE_W(LW), .OFS_W(OW), .DATA_W(DW)) u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_src_i, .busy_o,
    .mem_rd_o, .mem_line_o, .mem_rvalid_i, .mem_rdata_i,
    .msg_valid_o, .msg_type_o, .msg_dst_o, .msg_req_o, .msg_line_o, .msg_data_o
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit            ref_cached [NLINES];
  logic [NW-1:0] ref_holder [NLINES];
  int            mem_reads = 0;
  int            mem_cnt = 0;
  logic [LW-1:0] mem_pend = '0;
  logic [NW-1:0] last_dst = '0;
  logic [15:0]   lfsr = 16'hACE1;

  function automatic logic [DW-1:0] mem_val(input logic [LW-1:0] l);
    return DW'(16'h5A00 + 16'(l) * 16'd37);
  endfunction

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  // local memory model: fixed latency, driven on falling edges
  always @(negedge clk_i) begin
    mem_rvalid_i = 1'b0;
    if (mem_cnt != 0) begin
      mem_cnt--;
      if (mem_cnt == 0) begin
        mem_rvalid_i = 1'b1;
        mem_rdata_i  = mem_val(mem_pend);
      end
    end
    if (rst_ni && mem_rd_o) begin
      mem_reads++;
      mem_pend = mem_line_o;
      mem_cnt  = MEM_LAT;
    end
  end

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic do_req(input logic [NW-1:0] src, input logic [LW-1:0] line,
                        input logic [OW-1:0] ofs, input logic [NW-1:0] hnode,
                        input bit intrude);
    bit            exp_fwd;
    logic [NW-1:0] exp_dst;
    string         tag;
    int            reads0;
    int            lat;
    if (ref_cached[line] && ref_holder[line] != src) begin
      exp_fwd = 1; exp_dst = ref_holder[line]; tag = "R5";
    end else begin
      exp_fwd = 0; exp_dst = src;
      tag = ref_cached[line] ? "R6" : "R3";
    end
    ref_cached[line] = 1'b1;
    ref_holder[line] = src;

    @(negedge clk_i);
    while (busy_o) @(negedge clk_i);
    req_valid_i = 1'b1;
    req_src_i   = src;
    req_addr_i  = {hnode, line, ofs};
    reads0      = mem_reads;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("R7", "busy after accept", busy_o, 1);
    if (intrude) begin
      // R7: request while busy must be dropped
      req_valid_i = 1'b1;
      req_src_i   = NW'(NNODES - 1);
      req_addr_i  = {~hnode, INTR_LINE, ~ofs};
    end
    lat = 1;
    while (!msg_valid_o && lat < 20) begin
      if (!busy_o) chk("R7", "busy while pending", busy_o, 1);
      @(negedge clk_i);
      if (lat == 1) req_valid_i = 1'b0;
      lat++;
    end
    chk("R8", "message seen", msg_valid_o, 1);
    chk(tag, "latency", lat, exp_fwd ? 2 : 2 + MEM_LAT);
    chk("R7", "busy low at message", busy_o, 0);
    chk(tag, "type", msg_type_o, exp_fwd ? 1 : 0);
    chk(exp_fwd ? "R4" : tag, "dst", msg_dst_o, exp_dst);
    chk(tag, "requester", msg_req_o, src);
    chk("R1", "line", msg_line_o, line);
    chk(tag, "data", msg_data_o, exp_fwd ? 0 : mem_val(line));
    chk(tag, "memory reads", mem_reads - reads0, exp_fwd ? 0 : 1);
    if (!exp_fwd) chk("R1", "memory line", mem_pend, line);
    last_dst = msg_dst_o;
    @(negedge clk_i);
    chk("R8", "single-cycle message", msg_valid_o, 0);
  endtask

  initial begin
    for (int i = 0; i < NLINES; i++) begin
      ref_cached[i] = 1'b0;
      ref_holder[i] = '0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R2: idle outputs after reset
    chk("R2", "busy after reset", busy_o, 0);
    chk("R2", "msg_valid after reset", msg_valid_o, 0);
    chk("R2", "mem_rd after reset", mem_rd_o, 0);

    // R2 R3: first touch of every line is a memory reply
    for (int l = 0; l < NLINES; l++)
      do_req(NW'(l % NNODES), LW'(l), OW'(l), NW'(l * 3), 1'b0);

    // R4 R5 R6: every requester against every line in turn
    for (int l = 0; l < NLINES; l++)
      for (int n = 0; n < NNODES; n++)
        do_req(NW'(n), LW'(l), OW'(n + l), NW'(7 - n), 1'b0);

    // R1: scrambled offset and home-node fields
    for (int k = 0; k < 300; k++) begin
      step_lfsr();
      do_req(lfsr[2:0], lfsr[6:3], lfsr[8:7], lfsr[11:9], 1'b0);
    end

    // R7: intruding request while busy leaves INTR_LINE owned by node 2
    do_req(NW'(2), INTR_LINE, OW'(1), NW'(0), 1'b0);
    do_req(NW'(4), LW'(9), OW'(2), NW'(1), 1'b1);
    do_req(NW'(3), INTR_LINE, OW'(0), NW'(5), 1'b0);
    chk("R7", "ignored request left holder", last_dst, 2);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R8 watchdog act=%0d exp=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule